// File: doc/BRIEF.md
# Indirect-Access Lookup Table Memory

This block keeps a table of 96-bit lookup entries behind a narrow register window. The host never addresses the table directly. To store an entry it fills three 32-bit staging words and then writes the table-command register with the commit flag and an index. To fetch an entry it writes the same register with the commit flag clear; the entry lands in the staging words, which the host reads back on any later cycle.

Entry bit N maps to staging word 2 − N/32 at bit N mod 32. As a result the word at the lowest data offset holds entry bits 95:64, and the word at the highest data offset holds bits 31:0. The kind field that neighbouring logic decodes sits at entry bits 61:60, with this encoding: 0 = free, 1 = address, 2 = VLAN, 3 = VLAN+address.

The block also has a read-only identity word and a read-only size word, plus a global control register. That register holds an enable flag and a one-shot clear command. The clear command sweeps the table one entry per clock and marks each entry free. While the sweep runs, host writes to the table-command register are held off with a ready signal.

Top module: `lookup_table_win`

## Requirements
- R1: A read at offset 0x00 returns the major version in bits 15:8 and the minor version in bits 7:0, with all other bits zero.
- R2: A read at offset 0x04 returns the table size code in bits 4:0, equal to DEPTH/1024 when DEPTH is at least 1024 and 0 otherwise (0 means a 64-entry table). All other bits are zero.
- R3: The staging words at offsets 0x34, 0x38 and 0x3C read back the last value the host wrote to them.
- R4: Writing offset 0x20 with bit 31 set and an in-range index in bits IDXF_W-1:0 stores the staging words into that entry. The word at 0x34 supplies entry bits 95:64, 0x38 supplies bits 63:32, and 0x3C supplies bits 31:0. Offset 0x20 reads back the last index written.
- R5: Writing offset 0x20 with bit 31 clear loads the indexed entry into the staging words, using the same word-to-bit mapping as R4. The loaded values are visible on the next bus cycle.
- R6: A load with an index ≥ DEPTH sets all three staging words to zero. A commit with an index ≥ DEPTH changes no entry.
- R7: Writing 1 to bit 30 at offset 0x08 starts a sweep that sets bits 61:60 of every entry to 0 (free) and keeps the other bits. The sweep takes exactly DEPTH cycles, and bit 30 reads 1 for exactly those cycles.
- R8: While a sweep runs, a write to offset 0x20 is held with bus_ready low. It completes in the first cycle after the sweep ends. All other accesses are never held.
- R9: Bit 31 at offset 0x08 is a read/write enable flag that resets to 0.
- R10: After reset every entry, staging word, index and flag is zero.
- R11: Reads of unmapped offsets return zero, and writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request, held until bus_ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the request |
| bus_ready | output | 1 | Access completes at this clock edge |

## Verification
A corrupted table entry or a wrong word mapping stays hidden until the host reads that entry back. It then shows on the staging words one cycle after the load command, as bits shifted between words or stale values. A stuck or miscounted sweep shows at once on the clear flag at offset 0x08: it is held for the wrong number of cycles. The same fault also shows in the number of cycles a table-command write is held, and later as a kind field that is not free, or as other fields that got lost. A wrong range decision shows on the first out-of-range load as non-zero staging words, or as a modified in-range entry after an out-of-range commit.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  localparam int WORD_W  = 32;
  localparam int NWORDS  = 3;
  localparam int ENTRY_W = WORD_W * NWORDS;

  localparam logic [7:0] OFS_IDVER  = 8'h00;
  localparam logic [7:0] OFS_SIZE   = 8'h04;
  localparam logic [7:0] OFS_GCTRL  = 8'h08;
  localparam logic [7:0] OFS_TCMD   = 8'h20;
  localparam logic [7:0] OFS_DATA0  = 8'h34;

  localparam int COMMIT_BIT = 31;
  localparam int ENABLE_BIT = 31;
  localparam int CLEAR_BIT  = 30;
  localparam int KIND_LSB   = 60;

  typedef enum logic [1:0] {
    KIND_FREE      = 2'd0,
    KIND_ADDR      = 2'd1,
    KIND_VLAN      = 2'd2,
    KIND_VLAN_ADDR = 2'd3
  } entry_kind_e;

  typedef logic [NWORDS-1:0][WORD_W-1:0] word_set_t;

  // staging slot k carries entry bits [32*(2-k)+31 : 32*(2-k)]
  function automatic word_set_t split_entry(input logic [ENTRY_W-1:0] e);
    word_set_t w;
    for (int k = 0; k < NWORDS; k++) w[k] = e[WORD_W*(NWORDS-1-k) +: WORD_W];
    return w;
  endfunction

  function automatic logic [ENTRY_W-1:0] join_words(input word_set_t w);
    logic [ENTRY_W-1:0] e;
    for (int k = 0; k < NWORDS; k++) e[WORD_W*(NWORDS-1-k) +: WORD_W] = w[k];
    return e;
  endfunction

  function automatic logic [ENTRY_W-1:0] mark_free(input logic [ENTRY_W-1:0] e);
    logic [ENTRY_W-1:0] r;
    r = e;
    r[KIND_LSB +: 2] = KIND_FREE;
    return r;
  endfunction

  function automatic logic [4:0] size_code(input int unsigned depth);
    return (depth >= 1024) ? 5'(depth / 1024) : 5'd0;
  endfunction

  function automatic logic data_slot_hit(input logic [7:0] addr, input int unsigned k);
    return addr == (OFS_DATA0 + 8'(4 * k));
  endfunction
endpackage

// File: rtl/tbl_array.sv
module tbl_array
  import tbl_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [IDX_W-1:0]   host_idx,
  input  logic [ENTRY_W-1:0] host_data,
  input  logic               sweep_we,
  input  logic [IDX_W-1:0]   sweep_idx,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data
);
  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (sweep_we) begin
      mem[sweep_idx] <= mark_free(mem[sweep_idx]);
    end else if (host_we) begin
      mem[host_idx] <= host_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/tbl_sweeper.sv
module tbl_sweeper #(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (idx == LAST) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/tbl_regwin.sv
module tbl_regwin
  import tbl_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDXF_W = 10,
  parameter logic [7:0] VER_MAJOR = 8'h01,
  parameter logic [7:0] VER_MINOR = 8'h04,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_ready,
  input  logic               busy,
  input  logic [ENTRY_W-1:0] rd_entry,
  output logic [IDX_W-1:0]   tbl_idx,
  output logic [ENTRY_W-1:0] wr_entry,
  output logic               commit_fire,
  output logic               load_fire,
  output logic               idx_ok,
  output logic               clear_start,
  output word_set_t          stage_q
);
  localparam logic [31:0] ID_WORD   = {16'h0, VER_MAJOR, VER_MINOR};
  localparam logic [31:0] SIZE_WORD = {27'h0, size_code(DEPTH)};

  logic              tcmd_hit, wr_fire;
  logic [IDXF_W-1:0] idx_field, idx_q;
  logic              enable_q;

  assign tcmd_hit  = bus_sel && (bus_addr == OFS_TCMD);
  assign bus_ready = !(tcmd_hit && bus_wr && busy);
  assign wr_fire   = bus_sel && bus_wr && bus_ready;
  assign idx_field = bus_wdata[IDXF_W-1:0];
  assign idx_ok    = {1'b0, idx_field} < (IDXF_W + 1)'(DEPTH);
  assign tbl_idx   = idx_field[IDX_W-1:0];

  assign commit_fire = wr_fire && tcmd_hit && bus_wdata[COMMIT_BIT];
  assign load_fire   = wr_fire && tcmd_hit && !bus_wdata[COMMIT_BIT];
  assign clear_start = wr_fire && (bus_addr == OFS_GCTRL) && bus_wdata[CLEAR_BIT] && !busy;
  assign wr_entry    = join_words(stage_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      idx_q    <= '0;
      enable_q <= 1'b0;
    end else begin
      if (load_fire) stage_q <= idx_ok ? split_entry(rd_entry) : '0;
      else if (wr_fire) begin
        for (int k = 0; k < NWORDS; k++)
          if (data_slot_hit(bus_addr, k)) stage_q[k] <= bus_wdata;
      end
      if (wr_fire && tcmd_hit) idx_q <= idx_field;
      if (wr_fire && bus_addr == OFS_GCTRL) enable_q <= bus_wdata[ENABLE_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_IDVER: bus_rdata = ID_WORD;
      OFS_SIZE:  bus_rdata = SIZE_WORD;
      OFS_GCTRL: begin
        bus_rdata[ENABLE_BIT] = enable_q;
        bus_rdata[CLEAR_BIT]  = busy;
      end
      OFS_TCMD:  bus_rdata[IDXF_W-1:0] = idx_q;
      default: begin
        for (int k = 0; k < NWORDS; k++)
          if (data_slot_hit(bus_addr, k)) bus_rdata = stage_q[k];
      end
    endcase
  end
endmodule

// File: rtl/lookup_table_win.sv
module lookup_table_win
  import tbl_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDXF_W = 10,
  parameter logic [7:0] VER_MAJOR = 8'h01,
  parameter logic [7:0] VER_MINOR = 8'h04
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ready
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic               busy, commit_fire, load_fire, idx_ok, clear_start;
  logic [IDX_W-1:0]   tbl_idx, sweep_idx;
  logic [ENTRY_W-1:0] wr_entry, rd_entry;
  word_set_t          stage_q;

  tbl_regwin #(
    .DEPTH(DEPTH), .IDXF_W(IDXF_W), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
  ) u_win (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .bus_ready,
    .busy, .rd_entry, .tbl_idx, .wr_entry, .commit_fire, .load_fire, .idx_ok,
    .clear_start, .stage_q
  );

  tbl_sweeper #(.DEPTH(DEPTH)) u_sweep (
    .clk, .rst_n, .start(clear_start), .busy, .idx(sweep_idx)
  );

  tbl_array #(.DEPTH(DEPTH)) u_arr (
    .clk, .rst_n,
    .host_we(commit_fire && idx_ok), .host_idx(tbl_idx), .host_data(wr_entry),
    .sweep_we(busy), .sweep_idx(sweep_idx),
    .rd_idx(tbl_idx), .rd_data(rd_entry)
  );
endmodule

// File: rtl/lookup_table_win_chk.sv
module lookup_table_win_chk
  import tbl_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic             bus_ready,
  input logic             busy,
  input logic             commit_fire,
  input logic             load_fire,
  input logic             idx_ok,
  input logic             clear_start,
  input logic [IDX_W-1:0] sweep_idx,
  input word_set_t        stage_q
);
  int unsigned run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else run_cnt <= 0;
  end

  p_stall_tcmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_sel && bus_wr && bus_addr == OFS_TCMD |-> !bus_ready);

  p_idle_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_ready);

  p_no_commit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !commit_fire);

  p_oor_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire && !idx_ok |=> stage_q == '0);

  p_sweep_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> sweep_idx == IDX_W'($past(sweep_idx) + 1'b1));

  p_sweep_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(clear_start) && sweep_idx == '0);

  p_sweep_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == DEPTH);
endmodule

bind lookup_table_win lookup_table_win_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_ready(bus_ready), .busy(busy), .commit_fire(commit_fire), .load_fire(load_fire),
  .idx_ok(idx_ok), .clear_start(clear_start), .sweep_idx(sweep_idx), .stage_q(stage_q)
);

// File: tb/lookup_table_win_tb_top.sv
`timescale 1ns/1ps
module lookup_table_win_tb_top;
  localparam int DEPTH = 64;
  localparam logic [7:0] A_ID = 8'h00, A_SIZE = 8'h04, A_GC = 8'h08,
                         A_CMD = 8'h20, A_W0 = 8'h34, A_W1 = 8'h38, A_W2 = 8'h3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ready;

  int n_chk = 0, n_bad = 0;
  logic [95:0] model [DEPTH];

  always #2.5 clk = ~clk;

  lookup_table_win #(.DEPTH(DEPTH)) dut_i (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .bus_ready
  );

  function automatic logic [31:0] exp_word(input logic [95:0] e, input int k);
    logic [95:0] s;
    s = e >> (64 - 32 * k);
    return s[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d, output int stalls);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    stalls = 0;
    #1;
    while (!bus_ready) begin stalls++; @(negedge clk); #1; end
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    int s;
    bwr(a, d, s);
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic put_entry(input int idx, input logic [95:0] e);
    bw(A_W0, e[95:64]); bw(A_W1, e[63:32]); bw(A_W2, e[31:0]);
    bw(A_CMD, 32'h8000_0000 | idx);
    if (idx < DEPTH) model[idx] = e;
  endtask

  task automatic check_entry(input string req, input int idx);
    logic [31:0] d;
    logic [95:0] e;
    bw(A_CMD, idx);
    e = (idx < DEPTH) ? model[idx] : '0;
    brd(A_W0, d); check(req, d, exp_word(e, 0));
    brd(A_W1, d); check(req, d, exp_word(e, 1));
    brd(A_W2, d); check(req, d, exp_word(e, 2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int stalls, busy_cnt;
    void'($urandom(32'd2718));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    brd(A_W0, d); check("R10 stage0", d, 0);
    brd(A_W2, d); check("R10 stage2", d, 0);
    brd(A_GC, d); check("R10 gctrl", d, 0);
    brd(A_CMD, d); check("R10 index", d, 0);
    check_entry("R10 entry5", 5);

    // R1, R2, R9, R11
    brd(A_ID, d); check("R1 idver", d, 32'h0000_0104);
    brd(A_SIZE, d); check("R2 size", d, 32'h0);
    bw(A_GC, 32'h8000_0000);
    brd(A_GC, d); check("R9 enable set", d, 32'h8000_0000);
    bw(A_GC, 32'h0);
    brd(A_GC, d); check("R9 enable clr", d, 32'h0);
    bw(8'h10, 32'hFFFF_FFFF);
    brd(8'h10, d); check("R11 unmapped", d, 0);
    brd(A_W1, d); check("R11 no side effect", d, 0);

    // R3 staging readback
    bw(A_W0, 32'hA5A5_0001); bw(A_W1, 32'h5A5A_0002); bw(A_W2, 32'hC3C3_0003);
    brd(A_W0, d); check("R3 w0", d, 32'hA5A5_0001);
    brd(A_W1, d); check("R3 w1", d, 32'h5A5A_0002);
    brd(A_W2, d); check("R3 w2", d, 32'hC3C3_0003);

    // R4 word mapping: entry bit 0 -> word at 0x3C; kind bit 60 -> 0x38 bit 28
    put_entry(7, 96'h1);
    bw(A_CMD, 7);
    brd(A_W2, d); check("R4 bit0 in 0x3C", d, 1);
    brd(A_W0, d); check("R4 0x34 empty", d, 0);
    put_entry(8, 96'h1 << 60);
    bw(A_CMD, 8);
    brd(A_W1, d); check("R4 kind in 0x38", d, 32'h1000_0000);
    brd(A_CMD, d); check("R4 index readback", d, 8);
    put_entry(DEPTH - 1, {32'hFFFF_0000, 32'h1234_5678, 32'h0000_FFFF});
    check_entry("R5 last index", DEPTH - 1);

    // R6 out of range
    put_entry(0, {3{32'h0BAD_F00D}});
    check_entry("R6 oor load", DEPTH);
    put_entry(DEPTH, {3{32'hDEAD_BEEF}});
    check_entry("R6 oor commit alias0", 0);
    put_entry(1023, {3{32'h1111_2222}});
    check_entry("R6 oor commit entry63", DEPTH - 1);

    // R4/R5 random traffic
    for (int n = 0; n < 150; n++) begin
      int idx;
      logic [95:0] e;
      idx = $urandom_range(DEPTH - 1);
      e = {$urandom, $urandom, $urandom};
      if ($urandom_range(1) == 0) put_entry(idx, e);
      else check_entry("R5 random load", idx);
    end

    // R7 clear sweep: busy length and content
    put_entry(3, {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF});
    bw(A_GC, 32'h4000_0000);
    busy_cnt = 0;
    for (int g = 0; g < 4 * DEPTH; g++) begin
      brd(A_GC, d);
      if (d[30]) busy_cnt++;
      else break;
    end
    check("R7 busy cycles", busy_cnt, DEPTH);
    for (int i = 0; i < DEPTH; i++) model[i][61:60] = 2'b00;
    check_entry("R7 entry3 freed", 3);
    for (int n = 0; n < 20; n++) check_entry("R7 random freed", $urandom_range(DEPTH - 1));

    // R8 stall of table command during sweep
    bw(A_GC, 32'h4000_0000);
    bwr(A_CMD, 32'd3, stalls);
    check("R8 stall cycles", stalls, DEPTH);
    brd(A_W0, d); check("R8 load after stall", d, exp_word(model[3], 0));
    bw(A_GC, 32'h4000_0000);
    brd(A_ID, d); check("R8 other reg not held", d, 32'h0000_0104);
    bw(A_W0, 32'h7777_7777);
    brd(A_W0, d); check("R8 staging write during sweep", d, 32'h7777_7777);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule